// File: doc/BRIEF.md
# Eight-Bit Bidirectional I/O Port With Per-Pin Pullups

This block is one eight-bit general-purpose I/O port that sits on a simple memory-mapped register bus. It holds three registers: an output data latch, a direction register and a pullup-enable register. Together they drive three control signals for every pad: an output enable, an output value and a pullup enable. The level on each pin passes through a two-stage sampler and is returned through the data register address.

A read of the data address is decided bit by bit. A bit that is set up as an output returns what software last wrote. A bit that is set up as an input returns the sampled pin level. Writes to the data address always update the latch. Software can therefore preload the output value before it turns a pin around. The pullup of a pin is removed at once when its direction bit makes it an output.

The block has no state machine. Its only sequential state is the three registers and the sampler chain. The address decoder names four register selects: `SEL_NONE`, `SEL_DATA`, `SEL_DIR` and `SEL_PUE`. Each access goes straight to the select that its address picks, and no access depends on an earlier one.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted, and straight after it, the data latch, the direction register and the pullup-enable register are all zero. `pin_oe`, `pin_out` and `pin_pu` are all zero.
- R2: A read at the data address (default 0x03) returns, for each bit i, the latch bit when direction bit i is 1. When direction bit i is 0 it returns the synchronized pin level.
- R3: A write at the data address updates all eight latch bits whatever the direction bits hold. Bits written while they were inputs are returned by a data read once they become outputs.
- R4: The pullup-enable register at address 0x0F reads back the last value written to it.
- R5: The direction register at its parameter address (default 0x07) reads back the last value written to it.
- R6: `pin_pu[i]` is 1 only when pullup-enable bit i is 1 and direction bit i is 0.
- R7: `pin_oe[i]` equals direction bit i, and `pin_out[i]` equals latch bit i.
- R8: A change on `pin_in` shows in a data read of an input bit after exactly two rising clock edges. After one edge the read still shows the old level.
- R9: A read at any address other than the three register addresses returns zero.
- R10: A register changes only on a rising clock edge with `bus_wr_en` high and its own address selected. A write to an unmapped address, or bus activity with `bus_wr_en` low, leaves all three registers as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_wr_data | input | 8 | Write data |
| bus_rd_data | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin pullup enable |

## Verification
The assertions assume that `bus_addr`, `bus_wr_en` and `bus_wr_data` are stable around each rising edge. They also assume that `pin_in` changes only between edges, so the sampler's two-edge latency can be checked exactly. The stimulus drives every input on the falling edge. Each vector holds the pin level steady for three rising edges before it reads the data address, so reads of input bits always see a settled sampler. One directed test moves `pin_in` once and samples after the first and after the second edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Register select produced by the address decoder
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_PUE  = 2'd3
    } reg_sel_e;

    // Depth of the pin sampler chain
    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int unsigned           ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]     DATA_ADDR = 8'h03,
    parameter logic [ADDR_W-1:0]     DIR_ADDR  = 8'h07,
    parameter logic [ADDR_W-1:0]     PUE_ADDR  = 8'h0F
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if (addr == DATA_ADDR) begin
            sel = SEL_DATA;
        end else if (addr == DIR_ADDR) begin
            sel = SEL_DIR;
        end else if (addr == PUE_ADDR) begin
            sel = SEL_PUE;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [WIDTH-1:0] stage_q [SYNC_STAGES];

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        stage_q[s] <= '0;
                    end else begin
                        stage_q[s] <= pin_async;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        stage_q[s] <= '0;
                    end else begin
                        stage_q[s] <= stage_q[s-1];
                    end
                end
            end
        end
    endgenerate

    assign pin_sync = stage_q[LAST];

    // Checker bookkeeping: edges seen since reset, saturating at two
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R8
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (pin_sync == $past(pin_async, 2)));

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pue_q
);

    logic wr_latch;
    logic wr_dir;
    logic wr_pue;

    always_comb begin
        wr_latch = 1'b0;
        wr_dir   = 1'b0;
        wr_pue   = 1'b0;
        unique case (sel)
            SEL_DATA: wr_latch = wr_en;
            SEL_DIR:  wr_dir   = wr_en;
            SEL_PUE:  wr_pue   = wr_en;
            SEL_NONE: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr_latch) begin
            latch_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_dir) begin
            dir_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pue_q <= '0;
        end else if (wr_pue) begin
            pue_q <= wr_data;
        end
    end

    // R3
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DATA) |=> (latch_q == $past(wr_data)));

    // R5
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DIR) |=> (dir_q == $past(wr_data)));

    // R4
    pue_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_PUE) |=> (pue_q == $past(wr_data)));

    // R10
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || sel == SEL_NONE) |=>
            ($stable(latch_q) && $stable(dir_q) && $stable(pue_q)));

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pue_q,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] data_view;

    // Per-bit choice between the latch and the sampled pin
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_view
            assign data_view[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_DATA: rd_data = data_view;
            SEL_DIR:  rd_data = dir_q;
            SEL_PUE:  rd_data = pue_q;
            SEL_NONE: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned           WIDTH     = 8,
    parameter int unsigned           ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]     DATA_ADDR = 8'h03,
    parameter logic [ADDR_W-1:0]     DIR_ADDR  = 8'h07,
    parameter logic [ADDR_W-1:0]     PUE_ADDR  = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [WIDTH-1:0]  bus_wr_data,
    output logic [WIDTH-1:0]  bus_rd_data,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_pu
);

    reg_sel_e         sel;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pue_q;
    logic [WIDTH-1:0] pin_sync;

    gpio_addr_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_ADDR (DATA_ADDR),
        .DIR_ADDR  (DIR_ADDR),
        .PUE_ADDR  (PUE_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_reg_bank #(
        .WIDTH (WIDTH)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr_en   (bus_wr_en),
        .wr_data (bus_wr_data),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .pue_q   (pue_q)
    );

    gpio_pin_sync #(
        .WIDTH (WIDTH)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .pin_sync  (pin_sync)
    );

    gpio_read_mux #(
        .WIDTH (WIDTH)
    ) u_rdmux (
        .sel      (sel),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .pue_q    (pue_q),
        .pin_sync (pin_sync),
        .rd_data  (bus_rd_data)
    );

    // Pad control per pin; an output pin never keeps its pullup
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pad
            assign pin_oe[i]  = dir_q[i];
            assign pin_out[i] = latch_q[i];
            assign pin_pu[i]  = pue_q[i] & ~dir_q[i];
        end
    endgenerate

    // R6
    pullup_off_when_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    // R2
    data_read_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DATA_ADDR) |-> (((bus_rd_data ^ pin_out) & pin_oe) == '0));

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != DATA_ADDR && bus_addr != DIR_ADDR && bus_addr != PUE_ADDR)
            |-> (bus_rd_data == '0));

    // R7
    out_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == DATA_ADDR) |=> (pin_out == $past(bus_wr_data)));

endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

    localparam logic [7:0] A_DATA = 8'h03;
    localparam logic [7:0] A_DIR  = 8'h07;
    localparam logic [7:0] A_PUE  = 8'h0F;

    typedef struct packed {
        logic [3:0] rq;
        logic       wr;
        logic [7:0] addr;
        logic [7:0] wdata;
        logic [7:0] pin;
        logic [7:0] rd;
        logic [7:0] oe;
        logic [7:0] out;
        logic [7:0] pu;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{4'd4,  1'b1, 8'h0F, 8'hA5, 8'h00, 8'hA5, 8'h00, 8'h00, 8'hA5}, // R4 pue write
        '{4'd5,  1'b1, 8'h07, 8'h0F, 8'h00, 8'h0F, 8'h0F, 8'h00, 8'hA0}, // R5 low nibble out
        '{4'd2,  1'b1, 8'h03, 8'h3C, 8'hF0, 8'hFC, 8'h0F, 8'h3C, 8'hA0}, // R2 mixed read
        '{4'd10, 1'b0, 8'h03, 8'hFF, 8'h5A, 8'h5C, 8'h0F, 8'h3C, 8'hA0}, // R10 no strobe
        '{4'd6,  1'b1, 8'h07, 8'hF0, 8'h5A, 8'hF0, 8'hF0, 8'h3C, 8'h05}, // R6 gating flips
        '{4'd2,  1'b0, 8'h03, 8'h00, 8'h5A, 8'h3A, 8'hF0, 8'h3C, 8'h05}, // R2 other nibble
        '{4'd3,  1'b1, 8'h03, 8'hC3, 8'h00, 8'hC0, 8'hF0, 8'hC3, 8'h05}, // R3 write inputs too
        '{4'd7,  1'b1, 8'h07, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hC3, 8'h00}, // R7 all outputs
        '{4'd3,  1'b0, 8'h03, 8'h00, 8'h00, 8'hC3, 8'hFF, 8'hC3, 8'h00}, // R3 hidden bits appear
        '{4'd9,  1'b1, 8'h05, 8'h77, 8'h00, 8'h00, 8'hFF, 8'hC3, 8'h00}, // R9 unmapped
        '{4'd10, 1'b0, 8'h0F, 8'h00, 8'h00, 8'hA5, 8'hFF, 8'hC3, 8'h00}, // R10 pue untouched
        '{4'd4,  1'b1, 8'h0F, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hC3, 8'h00}, // R4 clear pue
        '{4'd6,  1'b1, 8'h07, 8'h00, 8'h00, 8'h00, 8'h00, 8'hC3, 8'h00}, // R6 inputs no pull
        '{4'd2,  1'b0, 8'h03, 8'h00, 8'h96, 8'h96, 8'h00, 8'hC3, 8'h00}  // R2 all pins
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr_en = 1'b0;
    logic [7:0] bus_wr_data = 8'h00;
    logic [7:0] bus_rd_data;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;
    logic [7:0] pin_pu;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    gpio_port u_gpio_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .bus_rd_data (bus_rd_data),
        .pin_in      (pin_in),
        .pin_oe      (pin_oe),
        .pin_out     (pin_out),
        .pin_pu      (pin_pu)
    );

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic read_at(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rd_data;
    endtask

    initial begin
        logic [7:0] rd;
        // R1 reset state
        repeat (3) @(negedge clk);
        read_at(A_DATA, rd); check("R1", "data", rd, 8'h00);
        read_at(A_DIR, rd);  check("R1", "dir",  rd, 8'h00);
        read_at(A_PUE, rd);  check("R1", "pue",  rd, 8'h00);
        check("R1", "oe",  pin_oe,  8'h00);
        check("R1", "out", pin_out, 8'h00);
        check("R1", "pu",  pin_pu,  8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        read_at(A_DIR, rd); check("R1", "dir after release", rd, 8'h00);

        // Table walk
        for (int k = 0; k < NVEC; k++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[k].rq);
            @(negedge clk);
            pin_in      = VECS[k].pin;
            bus_addr    = VECS[k].addr;
            bus_wr_data = VECS[k].wdata;
            bus_wr_en   = VECS[k].wr;
            @(negedge clk);
            bus_wr_en = 1'b0;
            repeat (2) @(negedge clk);
            check(tag, $sformatf("vec%0d rd", k),  bus_rd_data, VECS[k].rd);
            check(tag, $sformatf("vec%0d oe", k),  pin_oe,      VECS[k].oe);
            check(tag, $sformatf("vec%0d out", k), pin_out,     VECS[k].out);
            check(tag, $sformatf("vec%0d pu", k),  pin_pu,      VECS[k].pu);
        end

        // R8 sampler latency: all pins inputs, pin 96 settled
        bus_addr = A_DATA;
        pin_in   = 8'h3C;
        @(negedge clk);
        check("R8", "after one edge", bus_rd_data, 8'h96);
        @(negedge clk);
        check("R8", "after two edges", bus_rd_data, 8'h3C);

        // R1 reset in mid-run clears configured state
        bus_addr    = A_DIR;
        bus_wr_data = 8'hFF;
        bus_wr_en   = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        check("R7", "oe before reset", pin_oe, 8'hFF);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "oe in reset",  pin_oe,  8'h00);
        check("R1", "out in reset", pin_out, 8'h00);
        read_at(A_DIR, rd); check("R1", "dir in reset", rd, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule